// File: doc/BRIEF.md
# Accumulator Arithmetic Port Unit

This block is an arithmetic unit for a processor whose only instruction moves a value from one port address to another. It keeps one accumulator and answers to a small window of port addresses. A read of a port returns some view of the accumulator: the plain value, its bitwise inverse, its two's-complement negation, or one byte of it. A write to a port changes the accumulator: it loads it, adds to it, subtracts from it, shifts it, or replaces one byte. The port address together with the direction of the access chooses what happens. One port can do one thing on a read and another thing on a write.

The core's move engine drives the address, a read strobe and a write strobe. Read data comes back one clock after the read strobe. A zero flag shows at all times whether the accumulator holds zero, so that the core can use it for a conditional move.

Top module: `acc_port_unit`

## Requirements
- R1: While rst is high, the accumulator clears to zero and rd_data clears to zero. Once reset is released, acc_zero is 1.
- R2: Port 0x28 reads back the accumulator unchanged. A write to port 0x28 loads wr_data into the accumulator.
- R3: A read of port 0x29 returns the bitwise inverse of the accumulator. A write to port 0x29 adds wr_data to the accumulator, modulo 2^32. For example, writing 5 to an accumulator that holds x leaves x+5.
- R4: A read of port 0x2A returns the two's-complement negation of the accumulator. A write to port 0x2A subtracts wr_data from the accumulator, modulo 2^32.
- R5: A write to port 0x2B shifts the accumulator left, and a write to port 0x2C shifts it right logically (zeros fill from the top). The shift distance is wr_data[4:0], so a distance of 0 leaves the accumulator unchanged.
- R6: Ports 0x2D, 0x2E, 0x2F and 0x30 map to accumulator bytes 0, 1, 2 and 3. Byte 0 is bits 7:0. A read returns the selected byte zero-extended to 32 bits. A write puts wr_data[7:0] into that byte and leaves the other three bytes alone.
- R7: A read of any port never changes the accumulator. A read of port 0x2B or port 0x2C returns zero.
- R8: For an address outside 0x28 to 0x30, a read returns zero and a write leaves the accumulator unchanged.
- R9: rd_data takes its new value on the clock edge that samples rd_en, and holds that value until the next read. If a read and a write happen in the same cycle, the read returns the view of the accumulator as it stood before the write.
- R10: acc_zero is 1 exactly when the accumulator holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Port address of the current access |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read result |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write value |
| acc_zero | output | 1 | High when the accumulator is zero |

## Verification
The hard case is a read and a write in the same cycle, where the write changes the accumulator. The read must return the value from before the write. The stimulus makes these accesses both on the same port and across different ports, with each strobe driven on its own. Shift distances with upper bits set, such as 33, confirm that only the low five bits count. Sums that wrap to exactly zero exercise the zero flag at the carry boundary. After reads of every port and writes to addresses outside the window, a plain read of port 0x28 checks that the accumulator has not changed.

// File: rtl/acc_port_pkg.sv
package acc_port_pkg;
  // Write-side operation chosen by the port address
  typedef enum logic [2:0] {
    WOP_NONE, WOP_LOAD, WOP_ADD, WOP_SUB, WOP_SHL, WOP_SHR, WOP_BYTE
  } acc_wop_e;

  // Read-side view chosen by the port address
  typedef enum logic [2:0] {
    VIEW_ZERO, VIEW_PLAIN, VIEW_INV, VIEW_NEG, VIEW_BYTE
  } acc_view_e;

  // Ports that sit in front of the byte ports
  localparam int unsigned FIXED_PORTS = 5;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 8'h28,
  parameter int unsigned NBYTES = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win,
  output acc_wop_e          wop,
  output acc_view_e         view,
  output logic [NBYTES-1:0] byte_sel
);
  localparam int unsigned SPAN = FIXED_PORTS + NBYTES;

  logic [ADDR_W-1:0] offset;

  assign offset = addr - ADDR_W'(BASE);
  assign in_win = (addr >= ADDR_W'(BASE)) && (offset < ADDR_W'(SPAN));

  for (genvar k = 0; k < NBYTES; k++) begin : g_bsel
    assign byte_sel[k] = in_win && (offset == ADDR_W'(FIXED_PORTS + k));
  end

  always_comb begin
    wop  = WOP_NONE;
    view = VIEW_ZERO;
    if (in_win) begin
      case (offset)
        ADDR_W'(0): begin wop = WOP_LOAD; view = VIEW_PLAIN; end
        ADDR_W'(1): begin wop = WOP_ADD;  view = VIEW_INV;   end
        ADDR_W'(2): begin wop = WOP_SUB;  view = VIEW_NEG;   end
        ADDR_W'(3): begin wop = WOP_SHL;  view = VIEW_ZERO;  end
        ADDR_W'(4): begin wop = WOP_SHR;  view = VIEW_ZERO;  end
        default:    begin wop = WOP_BYTE; view = VIEW_BYTE;  end
      endcase
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_port_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NBYTES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] wr_data,
  input  acc_wop_e          wop,
  input  logic [NBYTES-1:0] byte_sel,
  output logic [DATA_W-1:0] acc_nxt
);
  localparam int unsigned SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]   shamt;
  logic [DATA_W-1:0] merged;

  assign shamt = wr_data[SH_W-1:0];

  for (genvar k = 0; k < NBYTES; k++) begin : g_merge
    assign merged[8*k +: 8] = byte_sel[k] ? wr_data[7:0] : acc[8*k +: 8];
  end

  always_comb begin
    case (wop)
      WOP_LOAD: acc_nxt = wr_data;
      WOP_ADD:  acc_nxt = acc + wr_data;
      WOP_SUB:  acc_nxt = acc - wr_data;
      WOP_SHL:  acc_nxt = acc << shamt;
      WOP_SHR:  acc_nxt = acc >> shamt;
      WOP_BYTE: acc_nxt = merged;
      default:  acc_nxt = acc;
    endcase
  end
endmodule

// File: rtl/acc_view.sv
module acc_view
  import acc_port_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NBYTES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] acc,
  input  acc_view_e         view,
  input  logic [NBYTES-1:0] byte_sel,
  output logic [DATA_W-1:0] rd_val
);
  logic [7:0] byte_pick [NBYTES+1];

  assign byte_pick[0] = 8'h00;
  for (genvar k = 0; k < NBYTES; k++) begin : g_pick
    assign byte_pick[k+1] = byte_pick[k] | (byte_sel[k] ? acc[8*k +: 8] : 8'h00);
  end

  always_comb begin
    case (view)
      VIEW_PLAIN: rd_val = acc;
      VIEW_INV:   rd_val = ~acc;
      VIEW_NEG:   rd_val = '0 - acc;
      VIEW_BYTE:  rd_val = {{(DATA_W-8){1'b0}}, byte_pick[NBYTES]};
      default:    rd_val = '0;
    endcase
  end
endmodule

// File: rtl/acc_port_unit.sv
module acc_port_unit
  import acc_port_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 8'h28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              acc_zero
);
  localparam int unsigned NBYTES = DATA_W / 8;
  localparam int unsigned SH_W   = $clog2(DATA_W);

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] acc_nxt;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rd_q;
  logic              in_win;
  acc_wop_e          wop;
  acc_view_e         view;
  logic [NBYTES-1:0] byte_sel;

  acc_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .NBYTES(NBYTES)) u_dec (
    .addr(addr), .in_win(in_win), .wop(wop), .view(view), .byte_sel(byte_sel)
  );

  acc_alu #(.DATA_W(DATA_W), .NBYTES(NBYTES)) u_alu (
    .acc(acc_q), .wr_data(wr_data), .wop(wop), .byte_sel(byte_sel), .acc_nxt(acc_nxt)
  );

  acc_view #(.DATA_W(DATA_W), .NBYTES(NBYTES)) u_view (
    .acc(acc_q), .view(view), .byte_sel(byte_sel), .rd_val(rd_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      rd_q  <= '0;
    end else begin
      if (wr_en && (wop != WOP_NONE)) acc_q <= acc_nxt;
      if (rd_en) rd_q <= rd_val;
    end
  end

  assign rd_data  = rd_q;
  assign acc_zero = (acc_q == '0);

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (acc_q == '0 && rd_q == '0));

  // R7
  read_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en) |=> $stable(acc_q));

  // R8
  outside_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !in_win) |=> $stable(acc_q));

  // R3
  add_wraps_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(BASE + 1)) |=> (acc_q == $past(acc_q) + $past(wr_data)));

  // R5
  zero_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == ADDR_W'(BASE + 3) || addr == ADDR_W'(BASE + 4))
     && wr_data[SH_W-1:0] == '0) |=> $stable(acc_q));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_q));
endmodule

// File: tb/acc_port_unit_tb.sv
module acc_port_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = 8'h00;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = 32'h0;
  logic [31:0] rd_data;
  logic        acc_zero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_acc = 32'h0;
  logic [31:0] m_rd  = 32'h0;

  always #10 clk = ~clk;

  acc_port_unit u_dut (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .rd_data(rd_data),
    .wr_en(wr_en), .wr_data(wr_data), .acc_zero(acc_zero)
  );

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(bit rd, bit wr, logic [7:0] a);
    if (!rd && !wr) return "R9 hold";
    if (a < 8'h28 || a > 8'h30) return "R8 outside";
    case (a)
      8'h28: return "R2 plain";
      8'h29: return "R3 inv/add";
      8'h2A: return "R4 neg/sub";
      8'h2B, 8'h2C: return wr ? "R5 shift" : "R7 write-only read";
      default: return "R6 byte";
    endcase
  endfunction

  function automatic logic [31:0] model_view(logic [31:0] acc, logic [7:0] a);
    case (a)
      8'h28: return acc;
      8'h29: return ~acc;
      8'h2A: return 32'h0 - acc;
      8'h2D: return {24'h0, acc[7:0]};
      8'h2E: return {24'h0, acc[15:8]};
      8'h2F: return {24'h0, acc[23:16]};
      8'h30: return {24'h0, acc[31:24]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] model_write(logic [31:0] acc, logic [7:0] a, logic [31:0] d);
    logic [31:0] r;
    r = acc;
    case (a)
      8'h28: r = d;
      8'h29: r = acc + d;
      8'h2A: r = acc - d;
      8'h2B: r = acc << d[4:0];
      8'h2C: r = acc >> d[4:0];
      8'h2D: r[7:0]   = d[7:0];
      8'h2E: r[15:8]  = d[7:0];
      8'h2F: r[23:16] = d[7:0];
      8'h30: r[31:24] = d[7:0];
      default: r = acc;
    endcase
    return r;
  endfunction

  // One access cycle, compared against the model on the following negedge
  task automatic cyc(bit rd, bit wr, logic [7:0] a, logic [31:0] d);
    string t;
    rd_en = rd; wr_en = wr; addr = a; wr_data = d;
    @(posedge clk);
    if (rd) m_rd = model_view(m_acc, a);
    if (wr) m_acc = model_write(m_acc, a, d);
    @(negedge clk);
    t = tag_of(rd, wr, a);
    if (rd && wr) t = {t, " R9 read-before-write"};
    check32(t, rd_data, m_rd);
    check32("R10 zero flag", {31'h0, acc_zero}, {31'h0, (m_acc == 32'h0)});
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd_acc();
    cyc(1'b1, 1'b0, 8'h28, 32'h0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    check32("R1 rd_data reset", rd_data, 32'h0);
    check32("R1 zero flag after reset", {31'h0, acc_zero}, 32'h1);
    rst = 1'b0;
    rd_acc();                              // R1 accumulator is zero
    // R6 build 0x000012A5 by byte writes, then R3 add 5
    cyc(1'b0, 1'b1, 8'h2D, 32'hFFFF_FFA5);
    cyc(1'b0, 1'b1, 8'h2E, 32'h0000_0012);
    rd_acc();
    cyc(1'b0, 1'b1, 8'h29, 32'd5);
    rd_acc();
    // R3/R4 views, reads leave acc alone (R7)
    cyc(1'b1, 1'b0, 8'h29, 32'h0);
    cyc(1'b1, 1'b0, 8'h2A, 32'h0);
    rd_acc();
    // R4 subtract through zero
    cyc(1'b0, 1'b1, 8'h2A, 32'h0000_12AA);
    cyc(1'b0, 1'b1, 8'h2A, 32'd1);
    rd_acc();
    cyc(1'b1, 1'b0, 8'h2A, 32'h0);
    // R3 wrap to zero
    cyc(1'b0, 1'b1, 8'h29, 32'd1);
    rd_acc();
    // R5 shifts, including distance with upper bits set and zero distance
    cyc(1'b0, 1'b1, 8'h28, 32'h8000_00F1);
    cyc(1'b0, 1'b1, 8'h2C, 32'd4);
    rd_acc();
    cyc(1'b0, 1'b1, 8'h2B, 32'd33);
    rd_acc();
    cyc(1'b0, 1'b1, 8'h2B, 32'hFFFF_FFE0);
    cyc(1'b0, 1'b1, 8'h2C, 32'd0);
    rd_acc();
    cyc(1'b0, 1'b1, 8'h2C, 32'd31);
    rd_acc();
    // R7 write-only ports read as zero
    cyc(1'b0, 1'b1, 8'h28, 32'hDEAD_BEEF);
    cyc(1'b1, 1'b0, 8'h2B, 32'h0);
    cyc(1'b1, 1'b0, 8'h2C, 32'h0);
    // R6 every byte read and write
    for (int k = 0; k < 4; k++) cyc(1'b1, 1'b0, 8'(8'h2D + k), 32'h0);
    for (int k = 0; k < 4; k++) begin
      cyc(1'b0, 1'b1, 8'(8'h2D + k), 32'h1234_5600 | 32'(k));
      rd_acc();
    end
    // R8 outside the window
    cyc(1'b0, 1'b1, 8'h27, 32'h1111_1111);
    cyc(1'b0, 1'b1, 8'h31, 32'h2222_2222);
    cyc(1'b0, 1'b1, 8'hFF, 32'h3333_3333);
    cyc(1'b1, 1'b0, 8'h27, 32'h0);
    cyc(1'b1, 1'b0, 8'h31, 32'h0);
    cyc(1'b1, 1'b0, 8'h00, 32'h0);
    rd_acc();
    // R9 idle holds, same-cycle read and write
    cyc(1'b0, 1'b0, 8'h28, 32'h0);
    cyc(1'b0, 1'b0, 8'h29, 32'h5);
    cyc(1'b1, 1'b1, 8'h28, 32'h0BAD_F00D);
    cyc(1'b1, 1'b1, 8'h29, 32'h10);
    cyc(1'b1, 1'b1, 8'h2E, 32'hAB);
    cyc(1'b1, 1'b1, 8'h2A, 32'h3);
    rd_acc();
    // Mixed pattern over the window and its edges
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0], lfsr[1], 8'(8'h26 + (lfsr[7:4] % 13)),
          {lfsr, lfsr[8:0], lfsr[15:9]} ^ 32'(i));
    end
    rd_acc();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule